// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches a set of asynchronous external lines, grouped into banks of 32, and turns selected signal edges into interrupt requests. Each line first passes through a two-flop synchroniser. A change in the synchronised value counts as an edge. A rising edge sets the line's rise-pending flag, and a falling edge sets its fall-pending flag, but only when that edge type is enabled for the line. Each line drives a level-high request while either flag is set and its interrupt mask bit is 1. A single combined request is the OR of all lines.

Software reaches the block through a simple 32-bit register port. Writes take effect on the rising clock edge; reads return combinationally. Through this port software selects trigger edges, masks lines, clears pending flags (write-one-to-clear), and raises software triggers. It can also find which lines exist: it writes all ones to a rise-select register and reads it back, since bits for absent lines never store a 1. The parameter `IMPL_MASK` marks which lines exist. `NUM_BANKS` may be 1 to 4.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every select, software-trigger, pending and mask register reads 0, and `irq_line` and `irq_any` are low.
- R2: Line n is bit n mod 32 of bank n/32. Bank b's trigger group starts at 0x20*b and holds: rise select at +0x00, fall select at +0x04, software trigger at +0x08, rise pending at +0x0C and fall pending at +0x10. Bank b's interrupt mask is at 0x80+0x10*b and its event mask at 0x84+0x10*b.
- R3: A line with only its rise-select bit set latches rising edges only. A line with only its fall-select bit set latches falling edges only. A line with both bits set latches both, each edge into its own pending register.
- R4: An input change first appears in a pending register after the third rising clock edge that follows it. It is not visible after the second.
- R5: Writing 1 to a pending bit clears it. Writing 0 to a pending bit leaves it unchanged.
- R6: Select bits of lines absent from `IMPL_MASK` always read 0, even after all ones are written. Under the default parameters, bank 2 reads back 0x000003FF.
- R7: `irq_line[n]` is high exactly when line n has a pending flag set and its interrupt mask bit is 1. `irq_any` is the OR of all `irq_line` bits.
- R8: Clearing a line's pending flags drops its `irq_line` bit even while the input holds its new level.
- R9: Writing 1 to a software-trigger bit sets that line's rise-pending flag on the same clock edge. The trigger bit reads 1 until the rise-pending flag is cleared, and then reads 0.
- R10: When an enabled edge and a pending clear for the same line fall on the same clock edge, the flag ends set.
- R11: Reads at unmapped offsets return 0. The event mask stores its value and reads it back, but has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_in | input | 32*NUM_BANKS | Asynchronous external lines |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_line | output | 32*NUM_BANKS | Per-line level-high interrupt requests |
| irq_any | output | 1 | OR of all per-line requests |

## Verification
Two functions can act on one pending flag in the same cycle: a synchronised edge setting it, and a software write-one-to-clear resetting it. The bench provokes the overlap by counting clock edges. It changes an input, waits two edges, then issues the clear so that the clear lands on the third edge, the same edge on which the latch occurs. It first sets the flag through an earlier edge, then reads the pending register. A flag that reads 1 shows that the edge won, while a flag that reads 0 shows that the clear took priority, which is wrong. A checker property also requires that an enabled edge is always followed by a set flag, whether or not a clear arrived with it.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NUM_BANKS = 3,
  parameter logic [NUM_BANKS*32-1:0] IMPL_MASK = {32'h0000_03FF, {64{1'b1}}}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_BANKS*32-1:0] ext_in,
  input  logic                    bus_wr,
  input  logic [7:0]              bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic [NUM_BANKS*32-1:0] irq_line,
  output logic                    irq_any
);
  localparam int LINES = NUM_BANKS * 32;

  logic [LINES-1:0] sync1, sync2, prev;
  logic [LINES-1:0] rsel, fsel, swtrig, rpend, fpend, imask, emask;
  logic [LINES-1:0] rclr, fclr, swset, rise_ev, fall_ev;
  logic [NUM_BANKS-1:0] we_rsel, we_fsel, we_imask, we_emask;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic thit, mhit;
    assign thit = bus_wr && !bus_addr[7] && bus_addr[6:5] == 2'(b);
    assign mhit = bus_wr && bus_addr[7:4] == 4'(8 + b);
    assign we_rsel[b]  = thit && bus_addr[4:0] == 5'h00;
    assign we_fsel[b]  = thit && bus_addr[4:0] == 5'h04;
    assign we_imask[b] = mhit && bus_addr[3:0] == 4'h0;
    assign we_emask[b] = mhit && bus_addr[3:0] == 4'h4;
    assign swset[b*32 +: 32] = (thit && bus_addr[4:0] == 5'h08) ? bus_wdata : '0;
    assign rclr[b*32 +: 32]  = (thit && bus_addr[4:0] == 5'h0C) ? bus_wdata : '0;
    assign fclr[b*32 +: 32]  = (thit && bus_addr[4:0] == 5'h10) ? bus_wdata : '0;
  end

  assign rise_ev = sync2 & ~prev & rsel;
  assign fall_ev = ~sync2 & prev & fsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      prev   <= '0;
      rsel   <= '0;
      fsel   <= '0;
      swtrig <= '0;
      rpend  <= '0;
      fpend  <= '0;
      imask  <= '0;
      emask  <= '0;
    end else begin
      sync1  <= ext_in;
      sync2  <= sync1;
      prev   <= sync2;
      rpend  <= ((rpend & ~rclr) | rise_ev | swset) & IMPL_MASK;
      fpend  <= ((fpend & ~fclr) | fall_ev) & IMPL_MASK;
      swtrig <= ((swtrig & ~rclr) | swset) & IMPL_MASK;
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (we_rsel[b])  rsel[b*32 +: 32]  <= bus_wdata & IMPL_MASK[b*32 +: 32];
        if (we_fsel[b])  fsel[b*32 +: 32]  <= bus_wdata & IMPL_MASK[b*32 +: 32];
        if (we_imask[b]) imask[b*32 +: 32] <= bus_wdata & IMPL_MASK[b*32 +: 32];
        if (we_emask[b]) emask[b*32 +: 32] <= bus_wdata & IMPL_MASK[b*32 +: 32];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (!bus_addr[7] && bus_addr[6:5] == 2'(b)) begin
        case (bus_addr[4:0])
          5'h00:   bus_rdata = rsel[b*32 +: 32];
          5'h04:   bus_rdata = fsel[b*32 +: 32];
          5'h08:   bus_rdata = swtrig[b*32 +: 32];
          5'h0C:   bus_rdata = rpend[b*32 +: 32];
          5'h10:   bus_rdata = fpend[b*32 +: 32];
          default: bus_rdata = '0;
        endcase
      end
      if (bus_addr[7:4] == 4'(8 + b)) begin
        case (bus_addr[3:0])
          4'h0:    bus_rdata = imask[b*32 +: 32];
          4'h4:    bus_rdata = emask[b*32 +: 32];
          default: bus_rdata = '0;
        endcase
      end
    end
  end

  assign irq_line = (rpend | fpend) & imask;
  assign irq_any  = |irq_line;
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk #(
  parameter int NUM_BANKS = 3,
  parameter logic [NUM_BANKS*32-1:0] IMPL_MASK = '1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_wr,
  input logic [7:0]              bus_addr,
  input logic [31:0]             bus_wdata,
  input logic [31:0]             bus_rdata,
  input logic [NUM_BANKS*32-1:0] rsel,
  input logic [NUM_BANKS*32-1:0] rpend,
  input logic [NUM_BANKS*32-1:0] fpend,
  input logic [NUM_BANKS*32-1:0] rise_ev,
  input logic [NUM_BANKS*32-1:0] fall_ev,
  input logic [NUM_BANKS*32-1:0] irq_line
);
  AST_SEL_IMPL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsel & ~IMPL_MASK) == '0); // R6

  AST_IRQ_IMPL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_line & ~IMPL_MASK) == '0); // R7

  AST_RCLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h0C && (&bus_wdata) && rise_ev[31:0] == '0)
      |=> rpend[31:0] == '0); // R5

  AST_FCLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h10 && (&bus_wdata) && fall_ev[31:0] == '0)
      |=> fpend[31:0] == '0); // R5

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev[0] |=> rpend[0]); // R10

  AST_SW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h08 && bus_wdata[0] && IMPL_MASK[0]) |=> rpend[0]); // R9

  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h7C || bus_addr == 8'h18) |-> bus_rdata == '0); // R11
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .IMPL_MASK(IMPL_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rsel(rsel), .rpend(rpend),
  .fpend(fpend), .rise_ev(rise_ev), .fall_ev(fall_ev), .irq_line(irq_line)
);

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;
  localparam int NB = 3;
  localparam int LN = NB * 32;
  localparam logic [LN-1:0] IMPL = {32'h0000_03FF, {64{1'b1}}};

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [LN-1:0] ext_in = '0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [LN-1:0] irq_line;
  logic irq_any;
  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  ext_irq_ctrl #(.NUM_BANKS(NB), .IMPL_MASK(IMPL)) i_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_line(irq_line), .irq_any(irq_any));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [LN-1:0] got, input logic [LN-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic chk_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, LN'(d), LN'(exp));
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [LN-1:0] exp_irq(input logic [LN-1:0] rp, input logic [LN-1:0] fp,
                                            input logic [LN-1:0] im);
    return (rp | fp) & im & IMPL;
  endfunction

  logic [LN-1:0] m_rsel, m_fsel, m_im, e_rp, e_fp, nin;
  logic [31:0] d;

  initial begin
    void'($urandom(32'd4242));
    #12 rst_n = 1;
    wait_neg(2);
    // R1 reset state
    chk_rd("R1 rsel0", 8'h00, 0);
    chk_rd("R1 rpend1", 8'h2C, 0);
    chk_rd("R1 imask2", 8'hA0, 0);
    chk("R1 irq_line", irq_line, '0);
    chk("R1 irq_any", LN'(irq_any), '0);
    // R6 implemented-line discovery
    wr(8'h40, 32'hFFFF_FFFF);
    chk_rd("R6 bank2 readback", 8'h40, 32'h0000_03FF);
    wr(8'h00, 32'hFFFF_FFFF);
    chk_rd("R6 bank0 readback", 8'h00, 32'hFFFF_FFFF);
    wr(8'h40, 0); wr(8'h00, 0);
    // R3/R4 rise only on line 3
    wr(8'h00, 32'h8); wr(8'h80, 32'h8);
    @(negedge clk); ext_in[3] = 1;
    wait_neg(2);
    chk_rd("R4 not yet after 2 edges", 8'h0C, 0);
    wait_neg(1);
    chk_rd("R4 latched after 3 edges", 8'h0C, 32'h8);
    chk("R7 irq_line3", irq_line, LN'(1) << 3);
    chk("R7 irq_any", LN'(irq_any), LN'(1));
    // R5 write zero no effect
    wr(8'h0C, 32'h0);
    chk_rd("R5 write0 keeps", 8'h0C, 32'h8);
    // R8 clear with input still high
    wr(8'h0C, 32'h8);
    chk_rd("R5 write1 clears", 8'h0C, 0);
    chk("R8 irq drops", irq_line, '0);
    chk("R8 irq_any drops", LN'(irq_any), '0);
    // R3 falling not selected on line 3
    @(negedge clk); ext_in[3] = 0;
    wait_neg(4);
    chk_rd("R3 fall ignored", 8'h10, 0);
    // R10 edge wins over coincident clear
    @(negedge clk); ext_in[3] = 1;
    wait_neg(4);
    @(negedge clk); ext_in[3] = 0;
    wait_neg(4);
    chk_rd("R10 pre-set", 8'h0C, 32'h8);
    @(negedge clk); ext_in[3] = 1;
    @(negedge clk);
    wr(8'h0C, 32'h8);
    chk_rd("R10 edge wins", 8'h0C, 32'h8);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h00, 0); wr(8'h80, 0);
    // R2/R3 both edges on line 40 (bank1 bit 8)
    wr(8'h20, 32'h100); wr(8'h24, 32'h100); wr(8'h90, 32'h100);
    @(negedge clk); ext_in[40] = 1;
    wait_neg(4);
    chk_rd("R3 both rise", 8'h2C, 32'h100);
    chk_rd("R3 both no fall yet", 8'h30, 0);
    @(negedge clk); ext_in[40] = 0;
    wait_neg(4);
    chk_rd("R3 both fall", 8'h30, 32'h100);
    chk("R7 irq_line40", irq_line, LN'(1) << 40);
    wr(8'h2C, 32'hFFFF_FFFF);
    chk("R7 still high on fall flag", irq_line, LN'(1) << 40);
    wr(8'h30, 32'hFFFF_FFFF);
    chk("R8 line40 drops", irq_line, '0);
    wr(8'h20, 0); wr(8'h24, 0); wr(8'h90, 0);
    // R2 bank2 line 70
    wr(8'h40, 32'h40); wr(8'hA0, 32'h40);
    @(negedge clk); ext_in[70] = 1;
    wait_neg(4);
    chk_rd("R2 bank2 pend", 8'h4C, 32'h40);
    chk("R2 line70 irq", irq_line, LN'(1) << 70);
    wr(8'h4C, 32'hFFFF_FFFF); wr(8'h40, 0); wr(8'hA0, 0);
    // R9 software trigger
    wr(8'h08, 32'h2);
    chk_rd("R9 sw sets rpend", 8'h0C, 32'h2);
    chk_rd("R9 sw bit reads 1", 8'h08, 32'h2);
    wr(8'h0C, 32'h2);
    chk_rd("R9 rpend cleared", 8'h0C, 0);
    chk_rd("R9 sw bit self-clears", 8'h08, 0);
    // R11 undefined offsets and event mask
    chk_rd("R11 undef 0x18", 8'h18, 0);
    chk_rd("R11 undef 0x7C", 8'h7C, 0);
    chk_rd("R11 undef 0xB0", 8'hB0, 0);
    wr(8'h84, 32'hF);
    chk_rd("R11 emask readback", 8'h84, 32'hF);
    chk("R11 emask no irq", irq_line, '0);
    wr(8'h84, 0);
    // Random phase: R3 R5 R7
    m_rsel = '0; m_fsel = '0; m_im = '0;
    for (int it = 0; it < 40; it++) begin
      int b;
      b = $urandom % NB;
      d = $urandom; wr(8'(b * 32), d);      m_rsel[b*32 +: 32] = d & IMPL[b*32 +: 32];
      d = $urandom; wr(8'(b * 32 + 4), d);  m_fsel[b*32 +: 32] = d & IMPL[b*32 +: 32];
      d = $urandom; wr(8'(128 + b * 16), d); m_im[b*32 +: 32] = d & IMPL[b*32 +: 32];
      nin = {$urandom, $urandom, $urandom};
      e_rp = nin & ~ext_in & m_rsel;
      e_fp = ~nin & ext_in & m_fsel;
      @(negedge clk); ext_in = nin;
      wait_neg(4);
      for (int k = 0; k < NB; k++) begin
        chk_rd("R3 random rpend", 8'(k * 32 + 12), e_rp[k*32 +: 32]);
        chk_rd("R3 random fpend", 8'(k * 32 + 16), e_fp[k*32 +: 32]);
      end
      chk("R7 random irq_line", irq_line, exp_irq(e_rp, e_fp, m_im));
      chk("R7 random irq_any", LN'(irq_any), LN'(|exp_irq(e_rp, e_fp, m_im)));
      for (int k = 0; k < NB; k++) begin
        wr(8'(k * 32 + 12), 32'hFFFF_FFFF);
        wr(8'(k * 32 + 16), 32'hFFFF_FFFF);
      end
      chk("R5 random all cleared", irq_line, '0);
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule